// File: doc/BRIEF.md
# Frame Gap Timer

This block sets the idle gap that a serial engine leaves between two frames. A free-running prescaler divides the block clock into a slow tick of roughly 100 ns. The divisor comes from a 32-bit input. For a fabric clock of F MHz seen at quarter rate, software writes F/40: 2400 MHz gives 60 cycles per tick.

When the serial engine finishes a frame it pulses a frame-end strobe. The block then captures a 17-bit gap setting and waits one block clock plus that many ticks, and then pulses a done output. The serial engine starts its next frame on that pulse. A setting of zero gives a one-clock gap. The tick phase is not aligned to the strobe, so a gap of N ticks is accurate to +0/-1 tick. The largest setting, 0x1FFFF, gives about 13.1 ms.

A strobe that arrives while a wait is running starts the wait again from the setting present at that strobe.

Top module: `pss_frame_gap_timer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `tick_o` and `gap_done_o` are 0. Both counters are cleared.
- R2: Let P be the value on `prescale_i`. With P held at 1 or more, `tick_o` is high for exactly one cycle in every P cycles. After reset release the first tick follows the P-th rising edge.
- R3: A `prescale_i` of 0 is treated as 1, so `tick_o` is high on every cycle.
- R4: A strobe sampled on edge E with a gap setting of 0 raises `gap_done_o` on edge E+1. That is exactly one block clock of gap.
- R5: With a setting N in 1..0x1FFFF, the block counts down N ticks. A tick counts only if `tick_o` is high on an edge after E while the remaining count is non-zero. `gap_done_o` rises on the first edge after the count has reached zero. The gap is therefore one clock plus N ticks, within +0/-1 tick.
- R6: `gap_done_o` is a single-cycle pulse. It occurs at most once per strobe.
- R7: A strobe sampled while a wait is running abandons that wait and starts a new one. No done pulse is produced for the abandoned wait.
- R8: The gap setting is captured on the strobe edge. Changes to `gap_setting_i` during a wait do not alter when `gap_done_o` rises.
- R9: When a strobe is sampled on the same edge at which a wait would complete, the strobe wins. No done pulse is produced on that edge, and a new wait starts.
- R10: Driving `rst_n` low in the middle of a wait abandons it. No done pulse follows after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_i | input | 32 | Tick divisor in block clocks (0 behaves as 1) |
| gap_setting_i | input | 17 | Gap length in ticks, captured at frame end |
| frame_end_i | input | 1 | One-cycle strobe marking the end of a frame |
| tick_o | output | 1 | One-cycle pulse every prescale cycles |
| gap_done_o | output | 1 | One-cycle pulse when the gap has elapsed |

## Verification
The hardest situation to reach from the ports is a strobe landing exactly on the edge where a wait would end, because that edge depends on the free-running tick phase. The bench watches its own reference model at the falling edge. When the model shows a running wait with nothing left to count, the bench drives the strobe into the completing edge. Mid-wait restarts, setting changes during a wait and reset in the middle of a wait are placed the same way. Randomised bursts of short settings and small divisors then sweep the tick phase against the strobe.

// File: rtl/pss_gap_pkg.sv
package pss_gap_pkg;
  localparam int unsigned PRESCALE_W = 32;
  localparam int unsigned GAP_W      = 17;

  typedef enum logic {
    GAP_IDLE = 1'b0,
    GAP_WAIT = 1'b1
  } gap_state_e;
endpackage

// File: rtl/gap_tick_gen.sv
module gap_tick_gen #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] prescale_i,
  output logic         tick_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] limit;
  logic         hit;
  logic         tick_q, tick_d;

  // divisor of zero behaves as one
  always_comb begin
    limit  = (prescale_i == '0) ? '0 : (prescale_i - ONE);
    hit    = (cnt_q >= limit);
    cnt_d  = hit ? '0 : (cnt_q + ONE);
    tick_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/gap_delay_ctr.sv
module gap_delay_ctr
  import pss_gap_pkg::*;
#(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         frame_end_i,
  input  logic [W-1:0] setting_i,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  gap_state_e   state_q, state_d;
  logic [W-1:0] rem_q, rem_d;
  logic         rem_en;
  logic         done_q, done_d;
  logic         rem_zero;

  assign rem_zero = (rem_q == '0);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    done_d  = 1'b0;
    if (frame_end_i) begin
      // strobe has priority: (re)start the wait with a fresh setting
      state_d = GAP_WAIT;
      rem_d   = setting_i;
      rem_en  = 1'b1;
    end else if (state_q == GAP_WAIT) begin
      if (rem_zero) begin
        done_d  = 1'b1;
        state_d = GAP_IDLE;
      end else if (tick_i) begin
        rem_d  = rem_q - ONE;
        rem_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GAP_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/pss_frame_gap_timer.sv
module pss_frame_gap_timer
  import pss_gap_pkg::*;
#(
  parameter int unsigned PRESCALE_BITS = PRESCALE_W,
  parameter int unsigned GAP_BITS      = GAP_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PRESCALE_BITS-1:0] prescale_i,
  input  logic [GAP_BITS-1:0]      gap_setting_i,
  input  logic                     frame_end_i,
  output logic                     tick_o,
  output logic                     gap_done_o
);
  logic tick;

  gap_tick_gen #(.W(PRESCALE_BITS)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .prescale_i (prescale_i),
    .tick_o     (tick)
  );

  gap_delay_ctr #(.W(GAP_BITS)) u_delay (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .frame_end_i (frame_end_i),
    .setting_i   (gap_setting_i),
    .done_o      (gap_done_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/pss_frame_gap_timer_chk.sv
module pss_frame_gap_timer_chk #(
  parameter int unsigned PRESCALE_BITS = 32,
  parameter int unsigned GAP_BITS      = 17
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PRESCALE_BITS-1:0] prescale_i,
  input logic [GAP_BITS-1:0]      gap_setting_i,
  input logic                     frame_end_i,
  input logic                     tick_o,
  input logic                     gap_done_o
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && prescale_i > 1) |=> !tick_o); // R2

  AST_TICK_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (prescale_i <= 1) |=> tick_o); // R3

  AST_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && gap_setting_i == '0) ##1 !frame_end_i |=> gap_done_o); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_done_o |=> !gap_done_o); // R6

  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> !gap_done_o); // R9
endmodule

bind pss_frame_gap_timer pss_frame_gap_timer_chk #(
  .PRESCALE_BITS (PRESCALE_BITS),
  .GAP_BITS      (GAP_BITS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .prescale_i    (prescale_i),
  .gap_setting_i (gap_setting_i),
  .frame_end_i   (frame_end_i),
  .tick_o        (tick_o),
  .gap_done_o    (gap_done_o)
);

// File: tb/tb_pss_frame_gap_timer.sv
`timescale 1ns/1ps
module tb_pss_frame_gap_timer;
  logic        clk;
  logic        rst_n;
  logic [31:0] prescale;
  logic [16:0] setting;
  logic        frame_end;
  logic        tick_o;
  logic        gap_done_o;

  int    vectors;
  int    miscompares;
  string cur_req;
  int    wd_cycles;

  // behavioural reference state
  longint m_pcnt;
  longint m_lim;
  int     m_tick;
  int     m_run;
  longint m_rem;
  int     m_done;
  int     old_tick;

  pss_frame_gap_timer dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .prescale_i    (prescale),
    .gap_setting_i (setting),
    .frame_end_i   (frame_end),
    .tick_o        (tick_o),
    .gap_done_o    (gap_done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pcnt = 0; m_tick = 0; m_run = 0; m_rem = 0; m_done = 0;
    end else begin
      old_tick = m_tick;
      m_lim = (prescale == 0) ? 0 : longint'(prescale) - 1;
      if (frame_end) begin
        m_run = 1; m_rem = setting; m_done = 0;
      end else if (m_run == 1) begin
        if (m_rem == 0) begin
          m_done = 1; m_run = 0;
        end else begin
          m_done = 0;
          if (old_tick == 1) m_rem = m_rem - 1;
        end
      end else begin
        m_done = 0;
      end
      if (m_pcnt >= m_lim) begin
        m_pcnt = 0; m_tick = 1;
      end else begin
        m_pcnt = m_pcnt + 1; m_tick = 0;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    vectors++;
    if (tick_o !== m_tick[0] || gap_done_o !== m_done[0]) begin
      miscompares++;
      $display("FAIL %s: tick/done actual=%b/%b expected=%0d/%0d at %0t",
               cur_req, tick_o, gap_done_o, m_tick, m_done, $time);
    end
  end

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary_and_end();
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic count_over(int n, output int ticks, output int dones);
    ticks = 0; dones = 0;
    repeat (n) begin
      @(negedge clk);
      if (tick_o) ticks++;
      if (gap_done_o) dones++;
    end
  endtask

  initial begin
    int t;
    int d;
    vectors = 0; miscompares = 0; wd_cycles = 0;
    cur_req = "R1";
    rst_n = 1'b0; prescale = 32'd5; setting = '0; frame_end = 1'b0;
    cyc(3);
    chk("R1 tick in reset", int'(tick_o), 0);
    chk("R1 done in reset", int'(gap_done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tick after release", int'(tick_o), 0);

    // R2: period and first tick position
    cur_req = "R2";
    cyc(3);
    @(negedge clk);
    chk("R2 first tick after 5th edge", int'(tick_o), 1);
    count_over(50, t, d);
    chk("R2 ticks in 50 cycles at P=5", t, 10);
    prescale = 32'd60;
    cyc(70);
    count_over(120, t, d);
    chk("R2 ticks in 120 cycles at P=60", t, 2);

    // R3: zero divisor
    cur_req = "R3";
    prescale = 32'd0;
    cyc(2);
    count_over(10, t, d);
    chk("R3 ticks in 10 cycles at P=0", t, 10);

    // R4: zero setting gives one clock
    cur_req = "R4";
    prescale = 32'd4; setting = 17'd0;
    cyc(3);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk("R4 done not yet after strobe edge", int'(gap_done_o), 0);
    @(negedge clk);
    chk("R4 done one edge later", int'(gap_done_o), 1);
    @(negedge clk);
    chk("R6 done falls after one cycle", int'(gap_done_o), 0);

    // R5: N ticks
    cur_req = "R5";
    setting = 17'd3;
    strobe();
    count_over(20, t, d);
    chk("R5 one done for N=3 P=4", d, 1);
    prescale = 32'd60; setting = 17'd2;
    strobe();
    count_over(200, t, d);
    chk("R5 one done for N=2 P=60", d, 1);

    // R7: restart mid-wait
    cur_req = "R7";
    prescale = 32'd3; setting = 17'd4;
    strobe();
    cyc(5);
    strobe();
    count_over(4, t, d);
    chk("R7 no done from abandoned wait", d, 0);
    count_over(20, t, d);
    chk("R7 one done from restarted wait", d, 1);

    // R8: setting changed during wait
    cur_req = "R8";
    setting = 17'd2;
    strobe();
    setting = 17'd40;
    count_over(15, t, d);
    chk("R8 done at captured setting", d, 1);
    setting = 17'd2;

    // R9: strobe on the completing edge
    cur_req = "R9";
    setting = 17'd1;
    strobe();
    while (!(m_run == 1 && m_rem == 0)) @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk("R9 no done on collision edge", int'(gap_done_o), 0);
    count_over(15, t, d);
    chk("R9 single done from new wait", d, 1);

    // R10: reset mid-wait
    cur_req = "R10";
    setting = 17'd5;
    strobe();
    cyc(3);
    rst_n = 1'b0;
    cyc(2);
    chk("R10 done low in reset", int'(gap_done_o), 0);
    rst_n = 1'b1;
    count_over(40, t, d);
    chk("R10 no done after reset", d, 0);

    // R6: randomised sweep of phase against strobe
    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      prescale = 32'($urandom_range(0, 7));
      setting  = 17'($urandom_range(0, 5));
      frame_end = ($urandom_range(0, 9) == 0);
    end
    frame_end = 1'b0;
    cyc(80);
    summary_and_end();
  end
endmodule